// File: doc/BRIEF.md
# Mixed-Signal Scan Test Controller

This block holds the digital test logic of a small mixed-signal scan component. A four-wire JTAG port, with an optional active-low asynchronous reset, steps a TAP state machine. That machine runs an 8-bit instruction register, a one-bit bypass path and a 14-bit boundary chain. The chain is built from three four-stage analog control groups and two digital cells. The first group sits nearest TDI and serves the analog bus interface. The second serves the analog input pin and the third the analog output pin. The digital input cell follows them, and the digital output cell feeds TDO.

Every analog group has four shift stages, named level, mode, line-A and line-B. Data from TDI enters the level stage and moves toward line-B, and line-B feeds the next element of the chain. Each group also has a parallel latch word. Test software places this word on the switch decoders. The block decodes the active instruction into two mode strobes for those decoders: `iso_m1` isolates pins from the core, and `test_m2` hands the switches to test control. The digital output pin is driven either from its scan latch or from the core.

The TAP states and their TMS-driven transitions are as follows. RESET stays on 1 and goes to IDLE on 0. IDLE stays on 0 and goes to SEL_DR on 1. SEL_DR goes to SEL_IR on 1 and to CAP_DR on 0. CAP_DR goes to EXIT1_DR on 1 and to SHIFT_DR on 0. SHIFT_DR stays on 0 and goes to EXIT1_DR on 1. EXIT1_DR goes to UPD_DR on 1 and to PAUSE_DR on 0. PAUSE_DR stays on 0 and goes to EXIT2_DR on 1. EXIT2_DR goes to UPD_DR on 1 and back to SHIFT_DR on 0. UPD_DR goes to SEL_DR on 1 and to IDLE on 0. SEL_IR goes to RESET on 1 and to CAP_IR on 0. The IR states CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR and UPD_IR mirror their DR counterparts.

Top module: `mst_ctrl`

## Requirements
- R1: Asserting `trst_n` low, or any clock edge spent in RESET, makes the active instruction BYPASS. It also clears every analog latch bit and the digital output latch, so `iso_m1`=0, `test_m2`=0 and `dpin_out` follows `dcore_out`.
- R2: The TAP machine follows the sixteen-state graph above on rising TCK edges. Five consecutive edges with TMS=1 reach RESET from any state.
- R3: The instruction register is 8 bits wide. Capture-IR loads 0x01, which shifts out LSB first. The new code takes effect at Update-IR. The codes are 0x00 EXTEST, 0x01 PROBE, 0x02 SAMPLE/PRELOAD and 0xFF BYPASS.
- R4: Under BYPASS the data path is one stage that captures 0. A scan of n bits returns 0 followed by the first n-1 bits shifted in. The latches do not change.
- R5: Under EXTEST, PROBE and SAMPLE/PRELOAD the chain has 14 bits. Chain bit k counts from the TDI end, and the bit shifted out first is bit 13. Bits 4g..4g+3 are group g as level, mode, line-A and line-B. Bit 12 is the digital input cell and bit 13 the digital output cell. `ctl_q[4g+3:4g]` carries group g's latch, with the level stage in bit 4g.
- R6: In Capture-DR, the level stage of group g loads `cmp_in[g]` and its mode, line-A and line-B stages load 0. Bit 12 loads `dpin_in` and bit 13 loads `dcore_out`.
- R7: The latches copy the chain only on an Update-DR edge under a boundary instruction. They hold through shifting, IR scans and every other state.
- R8: `iso_m1` is 1 only for EXTEST. `test_m2` is 1 for EXTEST and PROBE. Both are 0 for SAMPLE/PRELOAD and BYPASS.
- R9: `dpin_out` equals the digital output latch under EXTEST and equals `dcore_out` under every other instruction, including PROBE.
- R10: TDO changes only on falling TCK edges. `tdo_oe` is 1 exactly while the machine is in SHIFT_IR or SHIFT_DR.
- R11: Any code other than 0x00, 0x01 and 0x02 acts as BYPASS. The mode strobes stay low, the bypass stage is used, and the latches are left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Enable for the TDO pad's three-state driver |
| cmp_in | input | 3 | Comparator result per analog group |
| dpin_in | input | 1 | Level at the digital input pin |
| dcore_out | input | 1 | Core value destined for the digital output pin |
| dpin_out | output | 1 | Value driven onto the digital output pin |
| ctl_q | output | 12 | Latched control words of the three analog groups |
| iso_m1 | output | 1 | Pin isolation strobe for the switch decoders |
| test_m2 | output | 1 | Test-control strobe for the switch decoders |

## Verification
The first capture uses a comparator word that differs across the three groups. Its result shows whether each sense input lands in its own group's level bit, and whether the two digital captures keep their positions at the two ends of the chain. A second capture uses the opposite sense word while the shift stages still hold ones from the previous scan. It shows whether the mode and line stages really clear, rather than keeping shifted data. Bypass scans with two different serial patterns, one under the BYPASS code and one under an undefined code, tell a single delay stage apart from the boundary chain. The walk from SAMPLE/PRELOAD through EXTEST and PROBE separates the mode strobe values and the source of the digital output pin.

// File: rtl/mst_pkg.sv
package mst_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        OP_EXT, OP_PROBE, OP_SAMPLE, OP_BYP
    } op_t;

    localparam int IR_WIDTH = 8;
    localparam logic [IR_WIDTH-1:0] CODE_EXT    = 8'h00;
    localparam logic [IR_WIDTH-1:0] CODE_PROBE  = 8'h01;
    localparam logic [IR_WIDTH-1:0] CODE_SAMPLE = 8'h02;

endpackage

// File: rtl/mst_tap_fsm.sv
module mst_tap_fsm
    import mst_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    output logic tlr,
    output logic cap_ir,
    output logic sh_ir,
    output logic upd_ir,
    output logic cap_dr,
    output logic sh_dr,
    output logic upd_dr
);

    tap_state_t state, nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    always_comb begin
        tlr = 1'b0; cap_ir = 1'b0; sh_ir = 1'b0; upd_ir = 1'b0;
        cap_dr = 1'b0; sh_dr = 1'b0; upd_dr = 1'b0;
        unique case (state)
            TS_RESET:    tlr    = 1'b1;
            TS_CAP_IR:   cap_ir = 1'b1;
            TS_SHIFT_IR: sh_ir  = 1'b1;
            TS_UPD_IR:   upd_ir = 1'b1;
            TS_CAP_DR:   cap_dr = 1'b1;
            TS_SHIFT_DR: sh_dr  = 1'b1;
            TS_UPD_DR:   upd_dr = 1'b1;
            default: ;
        endcase
    end

    AST_RESET_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET && tms) |=> (state == TS_RESET)); // R2
    AST_SHIFT_LEAVES: assert property (@(posedge tck) disable iff (!trst_n)
        (sh_dr && tms) |=> (state == TS_EXIT1_DR)); // R2

endmodule

// File: rtl/mst_ir.sv
module mst_ir
    import mst_pkg::*;
#(
    parameter int W = IR_WIDTH
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tlr,
    input  logic cap,
    input  logic sh,
    input  logic upd,
    input  logic tdi,
    output logic ir_tdo,
    output logic m1,
    output logic m2,
    output logic dr_bsel
);

    localparam logic [W-1:0] CAP_PAT = {{(W-2){1'b0}}, 2'b01};

    logic [W-1:0] ir_sr, ir_q;
    op_t op;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= CAP_PAT;
            ir_q  <= '1;
        end else begin
            if (cap)     ir_sr <= CAP_PAT;
            else if (sh) ir_sr <= {tdi, ir_sr[W-1:1]};
            if (tlr)      ir_q <= '1;
            else if (upd) ir_q <= ir_sr;
        end
    end

    always_comb begin
        case (ir_q)
            CODE_EXT:    op = OP_EXT;
            CODE_PROBE:  op = OP_PROBE;
            CODE_SAMPLE: op = OP_SAMPLE;
            default:     op = OP_BYP;
        endcase
    end

    assign ir_tdo  = ir_sr[0];
    assign m1      = (op == OP_EXT);
    assign m2      = (op == OP_EXT) || (op == OP_PROBE);
    assign dr_bsel = (op != OP_BYP);

    AST_IR_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        tlr |=> (op == OP_BYP)); // R1
    AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
        cap |=> (ir_sr[1:0] == 2'b01)); // R3

endmodule

// File: rtl/mst_acell.sv
module mst_acell #(
    parameter int STG = 4
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           tlr,
    input  logic           cap,
    input  logic           sh,
    input  logic           upd,
    input  logic           sin,
    input  logic           sense,
    output logic           sout,
    output logic [STG-1:0] ctl
);

    logic [STG-1:0] stg;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stg <= '0;
            ctl <= '0;
        end else begin
            if (cap)     stg <= {{(STG-1){1'b0}}, sense};
            else if (sh) stg <= {stg[STG-2:0], sin};
            if (tlr)      ctl <= '0;
            else if (upd) ctl <= stg;
        end
    end

    assign sout = stg[STG-1];

    AST_CAP_CLEARS: assert property (@(posedge tck) disable iff (!trst_n)
        cap |=> (stg[STG-1:1] == '0)); // R6
    AST_LATCH_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
        (!upd && !tlr) |=> $stable(ctl)); // R7

endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
    import mst_pkg::*;
#(
    parameter int NUM_AC = 3,
    parameter int AC_W   = 4
) (
    input  logic                   tck,
    input  logic                   trst_n,
    input  logic                   tms,
    input  logic                   tdi,
    output logic                   tdo,
    output logic                   tdo_oe,
    input  logic [NUM_AC-1:0]      cmp_in,
    input  logic                   dpin_in,
    input  logic                   dcore_out,
    output logic                   dpin_out,
    output logic [NUM_AC*AC_W-1:0] ctl_q,
    output logic                   iso_m1,
    output logic                   test_m2
);

    logic tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
    logic ir_tdo, dr_bsel;
    logic b_cap, b_sh, b_upd;
    logic [NUM_AC-1:0] ac_in, ac_out;
    logic din_s, dout_s, dout_lat, byp_s, tdo_mux;

    mst_tap_fsm i_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tlr(tlr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
    );

    mst_ir #(.W(IR_WIDTH)) i_ir (
        .tck(tck), .trst_n(trst_n), .tlr(tlr),
        .cap(cap_ir), .sh(sh_ir), .upd(upd_ir), .tdi(tdi),
        .ir_tdo(ir_tdo), .m1(iso_m1), .m2(test_m2), .dr_bsel(dr_bsel)
    );

    assign b_cap = cap_dr && dr_bsel;
    assign b_sh  = sh_dr  && dr_bsel;
    assign b_upd = upd_dr && dr_bsel;

    for (genvar g = 0; g < NUM_AC; g++) begin : g_ac
        if (g == 0) begin : g_head
            assign ac_in[g] = tdi;
        end else begin : g_link
            assign ac_in[g] = ac_out[g-1];
        end
        mst_acell #(.STG(AC_W)) i_cell (
            .tck(tck), .trst_n(trst_n), .tlr(tlr),
            .cap(b_cap), .sh(b_sh), .upd(b_upd),
            .sin(ac_in[g]), .sense(cmp_in[g]),
            .sout(ac_out[g]), .ctl(ctl_q[g*AC_W +: AC_W])
        );
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            din_s    <= 1'b0;
            dout_s   <= 1'b0;
            dout_lat <= 1'b0;
            byp_s    <= 1'b0;
        end else begin
            if (b_cap) begin
                din_s  <= dpin_in;
                dout_s <= dcore_out;
            end else if (b_sh) begin
                din_s  <= ac_out[NUM_AC-1];
                dout_s <= din_s;
            end
            if (tlr)        dout_lat <= 1'b0;
            else if (b_upd) dout_lat <= dout_s;
            if (cap_dr && !dr_bsel)     byp_s <= 1'b0;
            else if (sh_dr && !dr_bsel) byp_s <= tdi;
        end
    end

    assign tdo_mux  = sh_ir ? ir_tdo : (dr_bsel ? dout_s : byp_s);
    assign dpin_out = iso_m1 ? dout_lat : dcore_out;

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_mux;
            tdo_oe <= sh_ir || sh_dr;
        end
    end

    AST_OE_WINDOW: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (sh_ir || sh_dr)); // R10
    AST_DLAT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (!b_upd && !tlr) |=> $stable(dout_lat)); // R7

endmodule

// File: tb/test_mst_ctrl.sv
module test_mst_ctrl;

    localparam int CLK_PER = 20;
    localparam int HALF    = CLK_PER / 2;

    logic        tck = 1'b0;
    logic        trst_n, tms, tdi;
    logic        tdo, tdo_oe;
    logic [2:0]  cmp_in;
    logic        dpin_in, dcore_out, dpin_out;
    logic [11:0] ctl_q;
    logic        iso_m1, test_m2;

    int errors = 0;
    int checks = 0;
    int edge_bad = 0;
    int hold_bad = 0;
    logic pre_oe;

    int          req_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] obs_q[$];

    mst_ctrl i_mst_ctrl (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe), .cmp_in(cmp_in),
        .dpin_in(dpin_in), .dcore_out(dcore_out), .dpin_out(dpin_out),
        .ctl_q(ctl_q), .iso_m1(iso_m1), .test_m2(test_m2)
    );

    initial forever #HALF tck = ~tck;

    // driver side: expected item first, then the observed result
    task automatic chk(input int r, input logic [31:0] got, input logic [31:0] exp);
        req_q.push_back(r);
        exp_q.push_back(exp);
        obs_q.push_back(got);
    endtask

    // monitor: pops and compares as results arrive
    initial forever begin
        int r;
        logic [31:0] e, o;
        wait (obs_q.size() != 0);
        r = req_q.pop_front();
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        checks++;
        if (o !== e) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", r, o, e);
        end
    end

    task automatic tick(input logic tms_v, input logic tdi_v, output logic tdo_v);
        logic pre;
        @(negedge tck);
        tms = tms_v;
        tdi = tdi_v;
        #(HALF - 1);
        pre    = tdo;
        pre_oe = tdo_oe;
        @(posedge tck);
        #1;
        if (tdo !== pre) edge_bad++;
        tdo_v = pre;
    endtask

    task automatic goto_idle();
        logic b;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    task automatic ir_scan(input logic [7:0] code, output logic [7:0] cap, output logic oe_seen);
        logic b;
        tick(1'b1, 1'b0, b);
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
        tick(1'b0, 1'b0, b);
        for (int i = 0; i < 8; i++) begin
            tick(i == 7, code[i], b);
            cap[i] = b;
            if (i == 0) oe_seen = pre_oe;
        end
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    task automatic dr_scan(input int n, input logic [15:0] din, output logic [15:0] dout);
        logic b;
        logic [11:0] h;
        dout = '0;
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
        tick(1'b0, 1'b0, b);
        h = ctl_q;
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[n-1-i], b);
            dout = {dout[14:0], b};
            if (ctl_q !== h) hold_bad++;
        end
        tick(1'b1, 1'b0, b);
        tick(1'b0, 1'b0, b);
    endtask

    initial begin
        #(CLK_PER * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  cap;
        logic [15:0] dout;
        logic        oe;
        trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
        cmp_in = 3'b000; dpin_in = 1'b0; dcore_out = 1'b1;
        #(3 * CLK_PER + 3);
        // R1: reset state
        chk(1, {20'd0, ctl_q}, 32'd0);
        chk(1, {30'd0, iso_m1, test_m2}, 32'd0);
        chk(1, {31'd0, dpin_out}, 32'd1);
        chk(10, {31'd0, tdo_oe}, 32'd0); // R10
        trst_n = 1'b1;
        goto_idle();

        // SAMPLE/PRELOAD
        ir_scan(8'h02, cap, oe);
        chk(3, {24'd0, cap}, 32'h01);          // R3 capture pattern
        chk(10, {31'd0, oe}, 32'd1);           // R10 enable while shifting
        chk(10, {31'd0, tdo_oe}, 32'd0);       // R10 idle, driver off
        chk(8, {30'd0, iso_m1, test_m2}, 32'd0); // R8

        cmp_in = 3'b101; dpin_in = 1'b1; dcore_out = 1'b0;
        dr_scan(14, 16'h2A5C, dout);
        chk(6, {16'd0, dout}, 32'h1101);       // R6 / R5 capture layout
        chk(7, {20'd0, ctl_q}, 32'hA5C);       // R7 preload copy, R5 mapping
        chk(9, {31'd0, dpin_out}, 32'd0);      // R9 core drives pin
        chk(7, hold_bad, 0);                   // R7 held while shifting
        chk(10, edge_bad, 0);                  // R10 falling-edge TDO

        // EXTEST
        ir_scan(8'h00, cap, oe);
        chk(8, {30'd0, iso_m1, test_m2}, 32'd3); // R8
        chk(9, {31'd0, dpin_out}, 32'd1);        // R9 latch drives pin
        cmp_in = 3'b010; dpin_in = 1'b0; dcore_out = 1'b1;
        dr_scan(14, 16'h0F0F, dout);
        chk(6, {16'd0, dout}, 32'h2010);       // R6 stages cleared over old ones
        chk(5, {20'd0, ctl_q}, 32'hF0F);       // R5
        chk(9, {31'd0, dpin_out}, 32'd0);      // R9

        // PROBE
        ir_scan(8'h01, cap, oe);
        chk(3, {24'd0, cap}, 32'h01);          // R3
        chk(8, {30'd0, iso_m1, test_m2}, 32'd1); // R8
        chk(9, {31'd0, dpin_out}, 32'd1);      // R9 transparent
        chk(7, {20'd0, ctl_q}, 32'hF0F);       // R7 IR scan leaves latches

        // BYPASS
        ir_scan(8'hFF, cap, oe);
        chk(8, {30'd0, iso_m1, test_m2}, 32'd0); // R8
        dr_scan(8, 16'h00B2, dout);
        chk(4, {16'd0, dout}, 32'h59);         // R4 one-stage delay
        chk(4, {20'd0, ctl_q}, 32'hF0F);       // R4 latches untouched

        // undefined code
        ir_scan(8'h5A, cap, oe);
        chk(11, {30'd0, iso_m1, test_m2}, 32'd0); // R11
        dr_scan(8, 16'h006D, dout);
        chk(11, {16'd0, dout}, 32'h36);        // R11 bypass path
        chk(11, {20'd0, ctl_q}, 32'hF0F);      // R11 latches untouched

        // EXTEST again, then TMS-high walk to RESET
        ir_scan(8'h00, cap, oe);
        goto_idle();
        chk(2, {20'd0, ctl_q}, 32'd0);         // R2 five TMS highs reach RESET
        chk(1, {30'd0, iso_m1, test_m2}, 32'd0); // R1
        chk(1, {31'd0, dpin_out}, 32'd1);      // R1 mission mode
        dr_scan(8, 16'h0081, dout);
        chk(1, {16'd0, dout}, 32'h40);         // R1 BYPASS after reset

        wait (obs_q.size() == 0);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule